// File: doc/BRIEF.md
# Half-band 2x interpolator with optional midscale stuffing

This block sits in front of a 14-bit DAC. It raises the sample rate of a stream of offset-binary samples. Each accepted input sample produces a burst of output samples on consecutive clocks of the output-rate clock. The core is a 43-tap half-band FIR split into two polyphase branches. The first branch is a 22-tap symmetric sum. The second branch is only the centre tap, so its output is simply a delayed input sample. The response is chosen at run time. In low-pass mode the baseband image is kept. In high-pass mode every other output sample is negated, which moves the passband up to the upper image.

An optional stuffing stage follows the filter. It places a midscale sample after each filtered sample, so one input sample yields four output samples instead of two. The stuffing raises the level and flatness of the higher-frequency images used for direct-IF output. Filtering uses signed arithmetic. The result is rounded to 14 bits and clamped at full scale instead of wrapping around. The mode pins are read only when a sample is accepted, so a burst never mixes two modes.

Top module: `interp2x_zstuff`

## Requirements
- R1: Samples at `in_sample` and `out_sample` are 14-bit offset binary. Code 0x2000 represents zero, and a code c carries the signed value c - 8192.
- R2: When `rst` is high at a clock edge, the block clears its 22-entry sample history to zero and ends any burst in progress. From then on it holds `out_valid` low and `out_sample` at 0x2000 until the next accepted sample.
- R3: A strobe on `in_valid` is accepted when no burst is running or when the running burst is in its last slot. The first output slot is registered one clock after the acceptance edge. The remaining slots follow on the next consecutive clocks, each with `out_valid` high.
- R4: A strobe that arrives while the running burst still has more than one slot left is ignored. Its sample does not enter the history and its mode is not taken.
- R5: Let h[0] be the newest accepted sample and h[21] the oldest. In low-pass mode (`mode[0]` = 0) a burst without stuffing is A then B. B = h[10]. A = round(sum over j = 0..10 of C[10-j]·(h[j] + h[21-j]) / 32768). The coefficients are C[0..10] = 20688, -6448, 3376, -1958, 1144, -645, 340, -162, 66, -19, 2.
- R6: A is rounded by adding 16384 and then shifting arithmetically right by 15. It is then clamped to the range -8192..8191.
- R7: In high-pass mode (`mode[0]` = 1), A is unchanged and B becomes -h[10]. Negating -8192 gives 8191.
- R8: With stuffing on (`mode[1]` = 1), the burst is four slots: A, 0x2000, B, 0x2000.
- R9: The mode used for a burst is the value on `mode` at its acceptance edge. Changes on `mode` between acceptances have no effect on the running burst.
- R10: On every clock where `out_valid` is low, `out_sample` is 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new input sample |
| in_sample | input | 14 | Input sample, offset binary |
| mode | input | 2 | Bit 0: high-pass response; bit 1: midscale stuffing |
| out_valid | output | 1 | High while a burst slot is presented |
| out_sample | output | 14 | Output sample, offset binary |

## Verification
On every cycle, the assertions check four things. The output rests at midscale whenever it is not valid. An accepted strobe always produces at least two valid slots. With stuffing selected, the second and fourth slots are midscale. The latched mode stays put for the whole burst. The bench's scenarios are needed to show the arithmetic: the coefficients seen in impulse responses, rounding and clamping under full-scale steps, the high-pass negation of the most negative code, the dropping of strobes that arrive too early, and the absence of leftover history after a mid-stream reset. All of these are compared slot by slot against a model kept in the bench.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   // number of distinct coefficient magnitudes on one side of the half-band centre
   localparam int HB_NPAIR = 11;
   localparam int HB_CW    = 16;

   typedef logic signed [HB_CW-1:0] coef_t;

   // index 0 is the pair nearest the centre; scaled so both sides sum to 2^15
   localparam coef_t HB_COEF [HB_NPAIR] = '{
      16'sd20688, -16'sd6448, 16'sd3376, -16'sd1958, 16'sd1144, -16'sd645,
      16'sd340,   -16'sd162,  16'sd66,   -16'sd19,   16'sd2
   };

endpackage

// File: rtl/hbi_dline.sv
module hbi_dline #(
   parameter int DW    = 14,
   parameter int DEPTH = 22
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift,
   input  logic signed [DW-1:0] din,
   output logic signed [DW-1:0] taps [DEPTH]
);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
      end else if (shift) begin
         taps[0] <= din;
         for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
      end
   end

endmodule

// File: rtl/hbi_mac.sv
module hbi_mac
   import hbi_pkg::*;
#(
   parameter int DW   = 14,
   parameter int CW   = HB_CW,
   parameter int FRAC = 15,
   parameter int ACCW = 36,
   parameter bit FOLD = 1'b1
)(
   input  logic signed [DW-1:0] taps [2*HB_NPAIR],
   output logic signed [DW-1:0] y
);

   localparam int NTAP  = 2 * HB_NPAIR;
   localparam int PW    = DW + 1 + CW;
   localparam int NPROD = FOLD ? HB_NPAIR : NTAP;
   localparam logic signed [ACCW-1:0] RND  = ACCW'(1) <<< (FRAC - 1);
   localparam logic signed [ACCW-1:0] YMAX = (ACCW'(1) <<< (DW - 1)) - ACCW'(1);
   localparam logic signed [ACCW-1:0] YMIN = -YMAX - ACCW'(1);

   logic signed [PW-1:0]   prod [NPROD];
   logic signed [ACCW-1:0] acc;
   logic signed [ACCW-1:0] rnd_sh;

   generate
      if (FOLD) begin : g_fold
         // symmetric taps share one multiplier through a pre-adder
         for (genvar j = 0; j < HB_NPAIR; j++) begin : g_p
            logic signed [DW:0] pre;
            assign pre     = (DW+1)'(taps[j]) + (DW+1)'(taps[NTAP-1-j]);
            assign prod[j] = PW'(pre) * PW'(HB_COEF[HB_NPAIR-1-j]);
         end
      end else begin : g_flat
         for (genvar i = 0; i < NTAP; i++) begin : g_p
            localparam int CI = (i < HB_NPAIR) ? (HB_NPAIR - 1 - i) : (i - HB_NPAIR);
            assign prod[i] = PW'(taps[i]) * PW'(HB_COEF[CI]);
         end
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < NPROD; k++) acc = acc + ACCW'(prod[k]);
   end

   assign rnd_sh = (acc + RND) >>> FRAC;

   always_comb begin
      if (rnd_sh > YMAX)      y = YMAX[DW-1:0];
      else if (rnd_sh < YMIN) y = YMIN[DW-1:0];
      else                    y = rnd_sh[DW-1:0];
   end

endmodule

// File: rtl/hbi_seq.sv
module hbi_seq #(
   parameter bit STUFF_EN = 1'b1
)(
   input  logic       clk,
   input  logic       rst,
   input  logic       in_valid,
   input  logic [1:0] mode_in,
   output logic       accept,
   output logic       active,
   output logic [1:0] ph,
   output logic [1:0] mode_q,
   output logic       hp,
   output logic       stuff
);

   logic last;

   generate
      if (STUFF_EN) begin : g_stuff
         assign stuff = mode_q[1];
      end else begin : g_nostuff
         assign stuff = 1'b0;
      end
   endgenerate

   assign hp     = mode_q[0];
   assign last   = stuff ? (ph == 2'd3) : (ph == 2'd1);
   assign accept = in_valid && (!active || last);

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         ph     <= 2'd0;
         mode_q <= 2'd0;
      end else if (accept) begin
         active <= 1'b1;
         ph     <= 2'd0;
         mode_q <= mode_in;
      end else if (active) begin
         if (last) begin
            active <= 1'b0;
            ph     <= 2'd0;
         end else begin
            ph <= ph + 2'd1;
         end
      end
   end

endmodule

// File: rtl/hbi_slot_mux.sv
module hbi_slot_mux #(
   parameter int DW       = 14,
   parameter bit STUFF_EN = 1'b1
)(
   input  logic [1:0]           ph,
   input  logic                 hp,
   input  logic                 stuff,
   input  logic signed [DW-1:0] a_val,
   input  logic signed [DW-1:0] ctr_val,
   output logic [DW-1:0]        slot
);

   localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

   logic signed [DW-1:0] b_val;
   logic signed [DW-1:0] pick;

   // high-pass: odd output-rate samples are negated, clamped at the top code
   always_comb begin
      if (!hp)                  b_val = ctr_val;
      else if (ctr_val == SMIN) b_val = SMAX;
      else                      b_val = -ctr_val;
   end

   generate
      if (STUFF_EN) begin : g_stuff
         always_comb begin
            if (stuff && ph[0])             pick = '0;
            else if (stuff ? ph[1] : ph[0]) pick = b_val;
            else                            pick = a_val;
         end
      end else begin : g_nostuff
         always_comb pick = ph[0] ? b_val : a_val;
      end
   endgenerate

   assign slot = {~pick[DW-1], pick[DW-2:0]};

endmodule

// File: rtl/interp2x_zstuff.sv
module interp2x_zstuff
   import hbi_pkg::*;
#(
   parameter int DW       = 14,
   parameter int CW       = HB_CW,
   parameter int FRAC     = 15,
   parameter int ACCW     = 36,
   parameter bit FOLD     = 1'b1,
   parameter bit STUFF_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_sample,
   input  logic [1:0]    mode,
   output logic          out_valid,
   output logic [DW-1:0] out_sample
);

   localparam int NTAP = 2 * HB_NPAIR;
   localparam int CTR  = HB_NPAIR - 1;
   localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

   if (DW < 4) begin : g_bad_dw
      $error("interp2x_zstuff: DW must be at least 4");
   end
   if (CW != HB_CW) begin : g_bad_cw
      $error("interp2x_zstuff: CW must match the coefficient set");
   end
   if (FRAC < 2 || FRAC >= ACCW - DW) begin : g_bad_frac
      $error("interp2x_zstuff: FRAC out of range");
   end
   if (ACCW < DW + 1 + CW + $clog2(HB_NPAIR) + 1) begin : g_bad_accw
      $error("interp2x_zstuff: ACCW too narrow for the sum");
   end

   logic signed [DW-1:0] x_in;
   logic signed [DW-1:0] taps [NTAP];
   logic signed [DW-1:0] a_val;
   logic                 accept;
   logic                 active;
   logic [1:0]           ph;
   logic [1:0]           mode_q;
   logic                 hp;
   logic                 stuff;
   logic [DW-1:0]        slot;

   assign x_in = {~in_sample[DW-1], in_sample[DW-2:0]};

   hbi_seq #(.STUFF_EN(STUFF_EN)) u_seq (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode_in(mode),
      .accept(accept), .active(active), .ph(ph), .mode_q(mode_q),
      .hp(hp), .stuff(stuff)
   );

   hbi_dline #(.DW(DW), .DEPTH(NTAP)) u_dline (
      .clk(clk), .rst(rst), .shift(accept), .din(x_in), .taps(taps)
   );

   hbi_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .ACCW(ACCW), .FOLD(FOLD)) u_mac (
      .taps(taps), .y(a_val)
   );

   hbi_slot_mux #(.DW(DW), .STUFF_EN(STUFF_EN)) u_mux (
      .ph(ph), .hp(hp), .stuff(stuff), .a_val(a_val), .ctr_val(taps[CTR]),
      .slot(slot)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_sample <= MID;
      end else if (active) begin
         out_valid  <= 1'b1;
         out_sample <= slot;
      end else begin
         out_valid  <= 1'b0;
         out_sample <= MID;
      end
   end

endmodule

// File: rtl/interp2x_zstuff_chk.sv
module interp2x_zstuff_chk #(
   parameter int DW       = 14,
   parameter bit STUFF_EN = 1'b1
)(
   input logic          clk,
   input logic          rst,
   input logic          accept,
   input logic          active,
   input logic [1:0]    mode,
   input logic [1:0]    mode_q,
   input logic          out_valid,
   input logic [DW-1:0] out_sample
);

   localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

   a_r10_idle_midscale: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (out_sample == MID));

   a_r3_two_slots: assert property (@(posedge clk) disable iff (rst)
      accept |=> ##1 out_valid ##1 out_valid);

   a_r8_mid_second: assert property (@(posedge clk) disable iff (rst)
      (accept && mode[1] && STUFF_EN) |=> ##2 (out_valid && out_sample == MID));

   a_r8_mid_fourth: assert property (@(posedge clk) disable iff (rst)
      (accept && mode[1] && STUFF_EN) |=> ##4 (out_valid && out_sample == MID));

   a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
      (active && !accept) |=> $stable(mode_q));

endmodule

bind interp2x_zstuff interp2x_zstuff_chk #(.DW(DW), .STUFF_EN(STUFF_EN)) u_chk (
   .clk(clk), .rst(rst), .accept(accept), .active(active), .mode(mode),
   .mode_q(mode_q), .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/tb_interp2x_zstuff.sv
module tb_interp2x_zstuff;

   localparam int MIDV = 8192;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [13:0] in_sample = 14'h2000;
   logic [1:0]  mode = 2'b00;
   logic        out_valid;
   logic [13:0] out_sample;

   interp2x_zstuff dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .mode(mode), .out_valid(out_valid), .out_sample(out_sample)
   );

   always #4 clk = ~clk;

   int    ecnt = 0;
   int    n_chk = 0;
   int    n_err = 0;
   string cur_req = "R2";
   int    ring_v [64];
   int    ring_d [64];
   int    hist [22];
   int    last_acc = -1000;
   int    last_len = 2;
   int    coef [11] = '{20688, -6448, 3376, -1958, 1144, -645, 340, -162, 66, -19, 2};

   always @(posedge clk) ecnt <= ecnt + 1;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int sat14(longint v);
      if (v > 8191) return 8191;
      if (v < -8192) return -8192;
      return int'(v);
   endfunction

   // compare every output slot against the model schedule
   always @(negedge clk) begin
      if (ecnt >= 1) begin
         int s;
         logic [31:0] expv;
         s = ecnt % 64;
         if (ring_v[s] != 0) expv = {17'b0, 1'b1, ring_d[s][13:0]};
         else                expv = {17'b0, 1'b0, 14'h2000};
         chk(cur_req, {17'b0, out_valid, out_sample}, expv);
         ring_v[s] = 0;
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(int s, logic [1:0] m);
      int c;
      c = ecnt + 1;
      in_sample = s[13:0];
      mode      = m;
      in_valid  = 1'b1;
      if (c >= last_acc + last_len) begin
         longint acc;
         int a, b, len;
         int sl [4];
         for (int k = 21; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = s - MIDV;
         acc = 0;
         for (int j = 0; j <= 10; j++)
            acc += longint'(coef[10-j]) * longint'(hist[j] + hist[21-j]);
         a = sat14((acc + 16384) >>> 15);
         b = m[0] ? sat14(-longint'(hist[10])) : hist[10];
         len = m[1] ? 4 : 2;
         if (m[1]) begin
            sl[0] = a + MIDV; sl[1] = MIDV; sl[2] = b + MIDV; sl[3] = MIDV;
         end else begin
            sl[0] = a + MIDV; sl[1] = b + MIDV; sl[2] = 0; sl[3] = 0;
         end
         for (int k = 0; k < len; k++) begin
            ring_v[(c + 1 + k) % 64] = 1;
            ring_d[(c + 1 + k) % 64] = sl[k];
         end
         last_acc = c;
         last_len = len;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic stream(int s, logic [1:0] m);
      push(s, m);
      idle(m[1] ? 3 : 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      for (int k = 0; k < 64; k++) ring_v[k] = 0;
      for (int k = 0; k < 22; k++) hist[k] = 0;
      last_acc = -1000;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   function automatic int sine(int i, real f, real amp);
      return MIDV + $rtoi(amp * $sin(2.0 * 3.14159265 * f * i));
   endfunction

   initial begin
      for (int k = 0; k < 22; k++) hist[k] = 0;
      for (int k = 0; k < 64; k++) begin ring_v[k] = 0; ring_d[k] = 0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10: idle output is midscale and not valid
      cur_req = "R10";
      idle(6);

      // R5: low-pass impulse exposes every coefficient, then a slow tone
      cur_req = "R5";
      stream(16383, 2'b00);
      for (int i = 0; i < 26; i++) stream(MIDV, 2'b00);
      for (int i = 0; i < 40; i++) stream(sine(i, 0.05, 7000.0), 2'b00);
      idle(6);

      // R7: high-pass impulse, most negative impulse (B clamps to 8191), fast tone
      cur_req = "R7";
      stream(16383, 2'b01);
      for (int i = 0; i < 24; i++) stream(MIDV, 2'b01);
      stream(0, 2'b01);
      for (int i = 0; i < 24; i++) stream(MIDV, 2'b01);
      for (int i = 0; i < 40; i++) stream(sine(i, 0.41, 7000.0), 2'b01);
      idle(6);

      // R8: four-slot bursts with midscale inserts, both responses
      cur_req = "R8";
      for (int i = 0; i < 30; i++) stream(sine(i, 0.12, 6500.0), 2'b10);
      stream(16383, 2'b11);
      for (int i = 0; i < 24; i++) stream(MIDV, 2'b11);
      idle(8);

      // R6: full-scale steps overshoot and must clamp; rounding on every A
      cur_req = "R6";
      for (int i = 0; i < 14; i++) stream(0, 2'b00);
      for (int i = 0; i < 14; i++) stream(16383, 2'b00);
      for (int i = 0; i < 14; i++) stream(0, 2'b00);
      for (int i = 0; i < 10; i++) stream(16383 - 3 * i, 2'b00);
      idle(6);

      // R4: strobes on every clock, most land mid-burst and are dropped
      cur_req = "R4";
      for (int i = 0; i < 24; i++) push(sine(i, 0.2, 8000.0), 2'b00);
      idle(4);
      for (int i = 0; i < 24; i++) push(sine(i, 0.07, 8000.0), 2'b10);
      idle(8);

      // R9: mode pin moves between acceptances without effect on the burst
      cur_req = "R9";
      for (int i = 0; i < 10; i++) begin
         push(sine(i, 0.15, 5000.0), 2'b10);
         mode = 2'b01;
         idle(3);
         push(sine(i, 0.31, 5000.0), 2'b01);
         mode = 2'b10;
         idle(1);
      end
      idle(6);

      // R3: back-to-back bursts at exact boundaries, cycling all modes
      cur_req = "R3";
      for (int i = 0; i < 32; i++) stream(sine(i, 0.09, 7500.0), 2'(i % 4));
      idle(2);
      for (int i = 0; i < 6; i++) begin
         push(sine(i, 0.3, 7000.0), 2'b00);
         idle(4);
      end
      idle(6);

      // R2: reset in the middle of a burst, then history must be clean
      cur_req = "R2";
      for (int i = 0; i < 12; i++) stream(16383, 2'b10);
      push(3000, 2'b10);
      do_reset();
      idle(3);
      stream(12000, 2'b00);
      for (int i = 0; i < 24; i++) stream(MIDV, 2'b00);
      idle(6);

      // R1: offset-binary tone near full scale
      cur_req = "R1";
      for (int i = 0; i < 40; i++) stream(sine(i, 0.23, 8150.0), 2'b00);
      idle(8);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule